// File: doc/BRIEF.md
# Hashed Object Handle Lookup Engine

This engine keeps a table of object entries in an attached single-port word RAM and serves one command at a time. A command is a lookup, an insert or a remove. Each carries a 32-bit object handle and a small channel number. An insert also carries the 32-bit context word to store. The engine folds the handle into a starting slot. It then walks the table one slot at a time, wrapping at the end, until the command is resolved or the walk has come back to the starting slot.

Each slot takes two RAM words: the handle and the context word. The RAM has a one-cycle read latency. The engine fetches the context word first and fetches the handle word only when the slot is occupied. The `cmd_legacy` input selects the older addressing and occupancy rules for the command it comes with. In that mode the channel number takes part in the hash, and only bit 31 of the context word marks a slot as occupied. Completion is reported with a single-cycle response carrying a status code and, for a lookup hit, the stored context word.

Top module: `ht_lookup_engine`

## Requirements
- R1: The starting slot is the XOR of the handle cut into HASH_BITS-wide pieces, least-significant piece first, with the last piece holding the remaining upper bits. The result is reduced modulo TABLE_ENTRIES, which is a power of two.
- R2: With `cmd_legacy` high, the channel number shifted left by HASH_BITS-4 is also XORed into the hash. With `cmd_legacy` low, the channel number has no effect on the starting slot.
- R3: Slot i uses RAM word 2i for the handle and word 2i+1 for the context word, which is byte offset 8i and 8i+4. Every slot write puts the handle word first and the context word in the next cycle.
- R4: With `cmd_legacy` high, a slot is occupied when bit 31 of its context word is 1. With `cmd_legacy` low, a slot is occupied when its context word is nonzero.
- R5: After a slot fails to resolve the command, the walk moves to the next slot, goes from the last slot to slot 0, and gives up once it would revisit the starting slot.
- R6: An insert writes the handle and context word into the first unoccupied slot in walk order and answers status 0. If no slot is free, it answers status 1 (full) and writes nothing.
- R7: A lookup hits only a slot that is occupied and whose stored handle equals the request. A hit answers status 0 with that slot's context word. A miss answers status 2 (not found) with `rsp_ctx` zero.
- R8: A remove writes zero to both words of the first occupied slot whose handle matches and answers status 0. If no slot matches, it answers status 2 and the table is unchanged.
- R9: Command codes are 2'b00 lookup, 2'b01 insert, and 2'b10 or 2'b11 remove. Status codes are 0 ok, 1 full and 2 not found; code 3 is never produced.
- R10: `cmd_ready` is high only while idle, so one command is outstanding at a time. `rsp_valid` is a one-cycle pulse. `cmd_ready` is already high in the pulse cycle, so a new command can be accepted there.
- R11: While `rst_n` is low at a clock edge, and after it, the engine is idle: `cmd_ready` high, `rsp_valid` low and `mem_en` low. Any command in progress is abandoned without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | Command code (R9) |
| cmd_legacy | input | 1 | Older hashing and occupancy rules for this command |
| cmd_handle | input | 32 | Object handle |
| cmd_chan | input | CHAN_W | Channel number |
| cmd_ctx | input | 32 | Context word to store on insert |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 full, 2 not found |
| rsp_ctx | output | 32 | Context word of a lookup hit, else zero |
| mem_en | output | 1 | RAM access this cycle |
| mem_we | output | 1 | RAM write when high, read when low |
| mem_addr | output | log2(TABLE_ENTRIES)+1 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after the read |

## Verification
The completion pulse of one command and the acceptance of the next can fall in the same cycle, because the engine is already idle while `rsp_valid` is high. The bench provokes this overlap by offering a second lookup in the very cycle it first sees the response of the first. It judges the result by requiring `cmd_ready` high in that cycle and both commands to return their own correct context words. A reset issued midway through a long miss is judged by requiring an immediate return to idle and no late response.

// File: rtl/ht_pkg.sv
// Shared types for the hashed handle lookup engine.
package ht_pkg;

    // Decoded command action
    typedef enum logic [1:0] {
        ACT_FIND = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_DROP = 2'd2
    } act_e;

    // Response status codes seen at the port
    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_FULL = 2'd1,
        RSP_MISS = 2'd2
    } rsp_e;

    // Walk controller states
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CTX,
        S_CHK_CTX,
        S_RD_HDL,
        S_CHK_HDL,
        S_WR_HDL,
        S_WR_CTX
    } walk_e;

    // Command code to action: bit 1 set means remove, else bit 0 picks insert
    function automatic act_e decode_op(input logic [1:0] op);
        if (op[1])
            return ACT_DROP;
        else if (op[0])
            return ACT_ADD;
        else
            return ACT_FIND;
    endfunction

endpackage

// File: rtl/ht_hash.sv
// Starting-slot hash.
// Folds the 32-bit handle in HASH_BITS pieces by XOR, optionally mixes in
// the channel number (legacy rule) and keeps the low IDX_W bits.
// Assumes 4 <= HASH_BITS <= 16 and a power-of-two table.
module ht_hash #(
    parameter int HASH_BITS = 9,
    parameter int CHAN_W    = 5,
    parameter int IDX_W     = 9
) (
    input  logic [31:0]       handle,
    input  logic [CHAN_W-1:0] chan,
    input  logic              legacy,
    output logic [IDX_W-1:0]  slot
);
    localparam int          CHUNKS     = (32 + HASH_BITS - 1) / HASH_BITS;
    localparam int          CH_SHIFT   = HASH_BITS - 4;
    localparam logic [31:0] CHUNK_MASK = (32'd1 << HASH_BITS) - 32'd1;

    logic [IDX_W-1:0] piece [CHUNKS];
    logic [IDX_W-1:0] chan_mix;

    // One masked piece of the handle per chunk position
    for (genvar k = 0; k < CHUNKS; k++) begin : g_piece
        assign piece[k] = IDX_W'((handle >> (k * HASH_BITS)) & CHUNK_MASK);
    end

    assign chan_mix = IDX_W'({{(32 - CHAN_W){1'b0}}, chan} << CH_SHIFT);

    // XOR all pieces together, then apply the legacy channel term
    always_comb begin
        slot = '0;
        for (int k = 0; k < CHUNKS; k++)
            slot = slot ^ piece[k];
        if (legacy)
            slot = slot ^ chan_mix;
    end

endmodule

// File: rtl/ht_entry_check.sv
// Slot test on the word returned by the RAM.
// occupied: occupancy rule of the active mode, valid when the word is a context word.
// key_match: word equals the requested handle, valid when the word is a handle word.
module ht_entry_check (
    input  logic [31:0] word,
    input  logic        legacy,
    input  logic [31:0] key,
    output logic        occupied,
    output logic        key_match
);
    // Mode-dependent occupancy and plain handle compare
    always_comb begin
        occupied  = legacy ? word[31] : (word != 32'd0);
        key_match = (word == key);
    end

endmodule

// File: rtl/ht_walk_ctrl.sv
// Command handshake, linear slot walk and RAM sequencing.
// Assumes a RAM with one-cycle read latency and a power-of-two slot count,
// so that the slot index wraps by plain overflow.
module ht_walk_ctrl
    import ht_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_legacy,
    input  logic [31:0]      cmd_handle,
    input  logic [31:0]      cmd_ctx,
    input  logic [IDX_W-1:0] start_slot,
    input  logic             occupied,
    input  logic             key_match,
    input  logic [31:0]      mem_rdata,
    output logic [31:0]      key_q,
    output logic             legacy_q,
    output logic             mem_en,
    output logic             mem_we,
    output logic [IDX_W:0]   mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [31:0]      rsp_ctx
);
    walk_e            state;
    act_e             act_q;
    rsp_e             code_q;
    logic [31:0]      ctx_q;
    logic [31:0]      hit_q;
    logic [31:0]      rctx_q;
    logic             rvalid_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] start_q;
    logic [IDX_W-1:0] idx_nxt;
    logic             lap_done;

    assign idx_nxt    = idx_q + IDX_W'(1);
    assign lap_done   = (idx_nxt == start_q);
    assign cmd_ready  = (state == S_IDLE);
    assign rsp_valid  = rvalid_q;
    assign rsp_status = code_q;
    assign rsp_ctx    = rctx_q;

    // Walk state, command capture and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            act_q    <= ACT_FIND;
            code_q   <= RSP_OK;
            ctx_q    <= '0;
            hit_q    <= '0;
            rctx_q   <= '0;
            rvalid_q <= 1'b0;
            idx_q    <= '0;
            start_q  <= '0;
            key_q    <= '0;
            legacy_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        act_q    <= decode_op(cmd_op);
                        key_q    <= cmd_handle;
                        ctx_q    <= cmd_ctx;
                        legacy_q <= cmd_legacy;
                        idx_q    <= start_slot;
                        start_q  <= start_slot;
                        state    <= S_RD_CTX;
                    end
                end
                S_RD_CTX: state <= S_CHK_CTX;
                S_CHK_CTX: begin
                    if (act_q == ACT_ADD && !occupied) begin
                        state <= S_WR_HDL;
                    end else if (act_q != ACT_ADD && occupied) begin
                        hit_q <= mem_rdata;
                        state <= S_RD_HDL;
                    end else if (lap_done) begin
                        rvalid_q <= 1'b1;
                        code_q   <= (act_q == ACT_ADD) ? RSP_FULL : RSP_MISS;
                        rctx_q   <= '0;
                        state    <= S_IDLE;
                    end else begin
                        idx_q <= idx_nxt;
                        state <= S_RD_CTX;
                    end
                end
                S_RD_HDL: state <= S_CHK_HDL;
                S_CHK_HDL: begin
                    if (key_match && act_q == ACT_FIND) begin
                        rvalid_q <= 1'b1;
                        code_q   <= RSP_OK;
                        rctx_q   <= hit_q;
                        state    <= S_IDLE;
                    end else if (key_match) begin
                        state <= S_WR_HDL;
                    end else if (lap_done) begin
                        rvalid_q <= 1'b1;
                        code_q   <= RSP_MISS;
                        rctx_q   <= '0;
                        state    <= S_IDLE;
                    end else begin
                        idx_q <= idx_nxt;
                        state <= S_RD_CTX;
                    end
                end
                S_WR_HDL: state <= S_WR_CTX;
                S_WR_CTX: begin
                    rvalid_q <= 1'b1;
                    code_q   <= RSP_OK;
                    rctx_q   <= '0;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // RAM strobes for the current state: odd word is context, even is handle
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {idx_q, 1'b0};
        mem_wdata = '0;
        unique case (state)
            S_RD_CTX: begin
                mem_en   = 1'b1;
                mem_addr = {idx_q, 1'b1};
            end
            S_RD_HDL: begin
                mem_en = 1'b1;
            end
            S_WR_HDL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = (act_q == ACT_ADD) ? key_q : 32'd0;
            end
            S_WR_CTX: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {idx_q, 1'b1};
                mem_wdata = (act_q == ACT_ADD) ? ctx_q : 32'd0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ht_lookup_engine.sv
// Hashed object handle lookup engine, top level.
// Hashes the offered command, walks the slot table held in an external
// single-port RAM (two words per slot, one-cycle read latency) and answers
// with a single-cycle response. TABLE_ENTRIES must be a power of two and
// the table is expected to be zero before first use.
module ht_lookup_engine #(
    parameter int HASH_BITS     = 9,
    parameter int TABLE_ENTRIES = 512,
    parameter int CHAN_W        = 5,
    localparam int IDX_W        = $clog2(TABLE_ENTRIES),
    localparam int AW           = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_legacy,
    input  logic [31:0]       cmd_handle,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [31:0]       cmd_ctx,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [31:0]       rsp_ctx,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    logic [IDX_W-1:0] start_slot;
    logic [31:0]      key_q;
    logic             legacy_q;
    logic             occupied;
    logic             key_match;

    ht_hash #(
        .HASH_BITS (HASH_BITS),
        .CHAN_W    (CHAN_W),
        .IDX_W     (IDX_W)
    ) u_hash (
        .handle (cmd_handle),
        .chan   (cmd_chan),
        .legacy (cmd_legacy),
        .slot   (start_slot)
    );

    ht_entry_check u_check (
        .word      (mem_rdata),
        .legacy    (legacy_q),
        .key       (key_q),
        .occupied  (occupied),
        .key_match (key_match)
    );

    ht_walk_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_legacy (cmd_legacy),
        .cmd_handle (cmd_handle),
        .cmd_ctx    (cmd_ctx),
        .start_slot (start_slot),
        .occupied   (occupied),
        .key_match  (key_match),
        .mem_rdata  (mem_rdata),
        .key_q      (key_q),
        .legacy_q   (legacy_q),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_ctx    (rsp_ctx)
    );

endmodule

// File: rtl/ht_lookup_engine_chk.sv
// Port-level protocol checks for ht_lookup_engine, attached by bind.
module ht_lookup_engine_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          rsp_valid,
    input logic [1:0]    rsp_status,
    input logic [31:0]   rsp_ctx,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);
    // R10: the engine is idle in the response cycle
    a_r10_ready_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cmd_ready);

    // R10: response lasts exactly one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: an accepted command closes the port
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R11: an idle engine makes no RAM access
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_en);

    // R9: status code 3 is never produced
    a_r9_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    // R7: unsuccessful answers carry a zero context
    a_r7_miss_ctx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_ctx == 32'd0));

    // R3: a handle-word write is followed by the context word of the same slot
    a_r3_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !mem_addr[0]) |=>
            (mem_en && mem_we && mem_addr[0] && (mem_addr[AW-1:1] == $past(mem_addr[AW-1:1]))));

    // R3: writes only ever happen with the RAM enabled
    a_r3_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

bind ht_lookup_engine ht_lookup_engine_chk #(
    .AW ($bits(mem_addr))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_ctx    (rsp_ctx),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/ht_lookup_engine_tb.sv
`timescale 1ns/1ps
module ht_lookup_engine_tb;
    localparam int HB = 6;
    localparam int NE = 16;
    localparam int CW = 5;
    localparam int AW = 5;
    localparam int NW = 2 * NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_legacy = 1'b0;
    logic [31:0]   cmd_handle = '0;
    logic [CW-1:0] cmd_chan = '0;
    logic [31:0]   cmd_ctx = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [31:0]   rsp_ctx;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    logic [31:0] ram [NW];
    logic [31:0] snap [NW];

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    ht_lookup_engine #(
        .HASH_BITS (HB),
        .TABLE_ENTRIES (NE),
        .CHAN_W (CW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_op (cmd_op), .cmd_legacy (cmd_legacy),
        .cmd_handle (cmd_handle), .cmd_chan (cmd_chan), .cmd_ctx (cmd_ctx),
        .rsp_valid (rsp_valid), .rsp_status (rsp_status), .rsp_ctx (rsp_ctx),
        .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    // Single-port RAM model, one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    typedef struct packed {
        logic [1:0]  op;
        logic        leg;
        logic [4:0]  ch;
        logic [31:0] h;
        logic [31:0] x;
        logic [1:0]  est;
        logic [31:0] ectx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 5'd0, 32'h0000_0011, 32'h8000_0101, 2'd0, 32'h0,          4'd6},
        '{2'd1, 1'b0, 5'd3, 32'h0000_1234, 32'h8000_0202, 2'd0, 32'h0,          4'd6},
        '{2'd0, 1'b0, 5'd0, 32'h0000_0011, 32'h0,         2'd0, 32'h8000_0101, 4'd7},
        '{2'd0, 1'b0, 5'd7, 32'h0000_1234, 32'h0,         2'd0, 32'h8000_0202, 4'd7},
        '{2'd0, 1'b0, 5'd0, 32'h0000_5555, 32'h0,         2'd2, 32'h0,          4'd7},
        '{2'd2, 1'b0, 5'd0, 32'h0000_0011, 32'h0,         2'd0, 32'h0,          4'd8},
        '{2'd0, 1'b0, 5'd0, 32'h0000_0011, 32'h0,         2'd2, 32'h0,          4'd7},
        '{2'd2, 1'b0, 5'd0, 32'h0000_0011, 32'h0,         2'd2, 32'h0,          4'd8},
        '{2'd3, 1'b0, 5'd0, 32'h0000_1234, 32'h0,         2'd0, 32'h0,          4'd9},
        '{2'd0, 1'b0, 5'd0, 32'h0000_1234, 32'h0,         2'd2, 32'h0,          4'd7}
    };

    // Reference starting slot, written from the requirement text
    function automatic int unsigned ref_slot(input logic [31:0] h, input logic [4:0] c, input bit leg);
        int unsigned acc = 0;
        logic [31:0] t = h;
        for (int used = 0; used < 32; used += HB) begin
            acc = acc ^ (t & ((32'd1 << HB) - 1));
            t = t >> HB;
        end
        if (leg) acc = acc ^ (int'(c) << (HB - 4));
        return acc % NE;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_ram();
        for (int i = 0; i < NW; i++) ram[i] = 32'd0;
    endtask

    task automatic drive(input logic [1:0] op, input bit leg, input logic [31:0] h,
                         input logic [4:0] c, input logic [31:0] x);
        cmd_op = op; cmd_legacy = leg; cmd_handle = h; cmd_chan = c; cmd_ctx = x;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [1:0] st, output logic [31:0] rc);
        int n = 0;
        while (!rsp_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) begin
            check("response timeout", 32'd0, 32'd1);
            st = 2'd3; rc = 32'hx;
        end else begin
            st = rsp_status; rc = rsp_ctx;
        end
    endtask

    task automatic run(input logic [1:0] op, input bit leg, input logic [31:0] h,
                       input logic [4:0] c, input logic [31:0] x,
                       output logic [1:0] st, output logic [31:0] rc);
        @(negedge clk);
        drive(op, leg, h, c, x);
        wait_rsp(st, rc);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", 150000);
        finish_run();
    end

    initial begin
        logic [1:0]  st;
        logic [31:0] rc;
        int unsigned s;
        int          slotj;
        int          diff;
        clear_ram();

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 ready in reset", {31'd0, cmd_ready}, 32'd1);
        check("R11 rsp low in reset", {31'd0, rsp_valid}, 32'd0);
        check("R11 no mem in reset", {31'd0, mem_en}, 32'd0);
        rst_n = 1'b1;

        // Table walk: insert, lookup, remove sequences
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].op, VECS[i].leg, VECS[i].h, VECS[i].ch, VECS[i].x, st, rc);
            check($sformatf("R%0d vec%0d status", VECS[i].req, i), {30'd0, st}, {30'd0, VECS[i].est});
            check($sformatf("R%0d vec%0d ctx", VECS[i].req, i), rc, VECS[i].ectx);
        end

        // R1, R3: placement of a folded handle, channel ignored in newer mode (R2)
        clear_ram();
        s = ref_slot(32'hDEAD_BEEF, 5'd0, 1'b0);
        run(2'd1, 1'b0, 32'hDEAD_BEEF, 5'd9, 32'h8000_0042, st, rc);
        check("R1 insert ok", {30'd0, st}, 32'd0);
        check("R1 R3 handle word", ram[2*s], 32'hDEAD_BEEF);
        check("R3 context word", ram[2*s+1], 32'h8000_0042);

        // R2: legacy mode mixes the channel number
        clear_ram();
        s = ref_slot(32'h0ABC_1357, 5'd3, 1'b1);
        run(2'd1, 1'b1, 32'h0ABC_1357, 5'd3, 32'h8300_0001, st, rc);
        check("R2 legacy handle word", ram[2*s], 32'h0ABC_1357);
        check("R2 legacy ctx word", ram[2*s+1], 32'h8300_0001);

        // R4: nonzero context without bit 31 is free in legacy mode
        clear_ram();
        ram[10] = 32'h77; ram[11] = 32'h55;
        run(2'd1, 1'b1, 32'h25, 5'd0, 32'h8000_00AA, st, rc);
        check("R4 legacy overwrite handle", ram[10], 32'h25);
        check("R4 legacy overwrite ctx", ram[11], 32'h8000_00AA);
        // R4: the same word is occupied in newer mode
        clear_ram();
        ram[10] = 32'h77; ram[11] = 32'h55;
        run(2'd1, 1'b0, 32'h25, 5'd0, 32'h8000_00AA, st, rc);
        check("R4 newer skips slot", ram[12], 32'h25);
        check("R4 newer keeps old", ram[10], 32'h77);
        run(2'd0, 1'b0, 32'h77, 5'd0, 32'h0, st, rc);
        check("R4 newer lookup hits", rc, 32'h55);
        run(2'd0, 1'b1, 32'h77, 5'd0, 32'h0, st, rc);
        check("R4 legacy lookup misses", {30'd0, st}, 32'd2);

        // R5: walk wraps from the last slot to slot 0
        clear_ram();
        ram[30] = 32'hAAAA; ram[31] = 32'h8000_0001;
        run(2'd1, 1'b0, 32'h0F, 5'd0, 32'h8000_000F, st, rc);
        check("R5 wrap handle", ram[0], 32'h0F);
        check("R5 wrap ctx", ram[1], 32'h8000_000F);
        run(2'd0, 1'b0, 32'h0F, 5'd0, 32'h0, st, rc);
        check("R5 wrap lookup", rc, 32'h8000_000F);

        // R6: fill the table, then the next insert reports full
        clear_ram();
        for (int i = 0; i < NE; i++) begin
            run(2'd1, 1'b0, 32'h100 + i, 5'd0, 32'h8000_0000 | i, st, rc);
            if (st != 2'd0) check("R6 fill", {30'd0, st}, 32'd0);
        end
        for (int i = 0; i < NW; i++) snap[i] = ram[i];
        run(2'd1, 1'b0, 32'h999, 5'd0, 32'h8000_0999, st, rc);
        check("R6 full status", {30'd0, st}, 32'd1);
        diff = 0;
        for (int i = 0; i < NW; i++) if (ram[i] !== snap[i]) diff++;
        check("R6 full writes nothing", diff, 32'd0);
        run(2'd0, 1'b0, 32'h999, 5'd0, 32'h0, st, rc);
        check("R7 full-table miss", {30'd0, st}, 32'd2);

        // R8: remove leaves a hole; later slots are still found
        slotj = -1;
        for (int i = 0; i < NE; i++) if (ram[2*i] == 32'h103) slotj = i;
        run(2'd2, 1'b0, 32'h103, 5'd0, 32'h0, st, rc);
        check("R8 remove ok", {30'd0, st}, 32'd0);
        check("R8 handle zeroed", ram[2*slotj], 32'd0);
        check("R8 ctx zeroed", ram[2*slotj+1], 32'd0);
        diff = 0;
        for (int i = 0; i < NE; i++) begin
            if (i != 3) begin
                run(2'd0, 1'b0, 32'h100 + i, 5'd0, 32'h0, st, rc);
                if (rc != (32'h8000_0000 | i)) diff++;
            end
        end
        check("R7 lookups past hole", diff, 32'd0);
        run(2'd1, 1'b0, 32'h999, 5'd0, 32'h8000_0999, st, rc);
        check("R6 insert into hole", ram[2*slotj], 32'h999);

        // R10: next command offered in the response cycle
        @(negedge clk);
        drive(2'd0, 1'b0, 32'h10A, 5'd0, 32'h0);
        wait_rsp(st, rc);
        check("R10 ready in rsp cycle", {31'd0, cmd_ready}, 32'd1);
        check("R10 first result", rc, 32'h8000_000A);
        drive(2'd0, 1'b0, 32'h10B, 5'd0, 32'h0);
        wait_rsp(st, rc);
        check("R10 second result", rc, 32'h8000_000B);

        // R11: reset during a long miss abandons it
        @(negedge clk);
        drive(2'd0, 1'b0, 32'h5555, 5'd0, 32'h0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R11 ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R11 no mem after reset", {31'd0, mem_en}, 32'd0);
        diff = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (rsp_valid) diff++;
        end
        check("R11 no late response", diff, 32'd0);

        finish_run();
    end

endmodule